// File: doc/BRIEF.md
# TLB Entry Programming Port

This block is the register front end that software uses to load a software-managed translation buffer shared by two MMU contexts. Software first writes a selector register, which chooses a set and an index. It then writes an upper-word register and finally a lower-word register. Writing the lower word commits one full two-word entry into the translation storage.

A write to the upper-word register also loads the fault-cause register in the same cycle. The committed entry takes its upper word from that cause register. The lower-word register is not kept separately: its value goes straight into the entry. The write strobe carries a register address and 32-bit data. It is qualified by the number of the special-register bank that is active at the time. Only banks 1 and 2 reach the buffer, and each of them owns an independent storage array.

A lookup port with a one-cycle read latency returns the stored words for an array, set and index chosen by the caller. The selector, upper-word and cause registers can be read back at any time.

Top module: `tlbw_port`

## Requirements
- R1: A write of any register while `reg_bank` is neither 1 nor 2 changes no register and no stored entry.
- R2: A write to address 1 (upper word) in bank 1 or 2 loads `hi_q` and `cause_q` with `wr_data`, both visible after the same clock edge.
- R3: A write to address 0 (selector) in bank 1 or 2 loads `sel_q`. Bits [3:0] are the entry index and bits [5:4] are the set.
- R4: A write to address 2 (lower word) in bank 1 or 2 stores an entry whose lower word is `wr_data` and whose upper word is the current `cause_q`, at the set and index held in `sel_q`.
- R5: Bank 1 commits into array 0 and bank 2 into array 1 (`lk_arr` 0 and 1). A commit in one array leaves the other untouched.
- R6: `lk_hi` and `lk_lo` show the entry addressed by `lk_arr`, `lk_set` and `lk_idx` at the previous clock edge. A commit at that same edge appears one edge later.
- R7: After reset, `sel_q`, `hi_q` and `cause_q` are zero and every entry reads as zero.
- R8: A stored entry keeps its upper word when the upper-word and cause registers are written afterwards.
- R9: A write to address 3 (cause) has no effect, so the cause register changes only through upper-word writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 selector, 1 upper word, 2 lower word, 3 cause |
| wr_data | input | 32 | Write data |
| reg_bank | input | 4 | Active special-register bank number |
| sel_q | output | 32 | Selector register readback |
| hi_q | output | 32 | Upper-word register readback |
| cause_q | output | 32 | Cause register readback |
| lk_arr | input | 1 | Lookup array (0 for bank 1, 1 for bank 2) |
| lk_set | input | 2 | Lookup set |
| lk_idx | input | 4 | Lookup index |
| lk_hi | output | 32 | Upper word of the looked-up entry |
| lk_lo | output | 32 | Lower word of the looked-up entry |

## Verification
The hardest case to reach from the ports is a commit and a lookup of the same entry at the same clock edge. In that case the read must still return the old contents, and the new contents must appear only one edge later. The stimulus parks the lookup address on an unused entry before it starts the write sequence. It then samples the lookup output after the commit edge and again after the following edge. A table of programming steps spreads entries over both arrays and over the corner sets and indices. Some steps use banks outside 1 and 2, and those entries are then read back as still zero.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  typedef enum logic [1:0] {
    RA_SEL   = 2'd0,
    RA_HI    = 2'd1,
    RA_LO    = 2'd2,
    RA_CAUSE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tlbw_regs.sv
module tlbw_regs #(
  parameter int DATA_W  = 32,
  parameter int BANK_W  = 4,
  parameter int NUM_ARR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BANK_W-1:0] reg_bank,
  output logic [DATA_W-1:0] sel_q,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] cause_q,
  output logic              commit
);
  import tlbw_pkg::*;

  reg_addr_e ra;
  logic      bank_ok;
  logic      wr_ok;

  assign ra      = reg_addr_e'(wr_addr);
  assign bank_ok = (reg_bank >= BANK_W'(1)) && (reg_bank <= BANK_W'(NUM_ARR));
  assign wr_ok   = wr_en && bank_ok;
  assign commit  = wr_ok && (ra == RA_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      hi_q    <= '0;
      cause_q <= '0;
    end else if (wr_ok) begin
      case (ra)
        RA_SEL: sel_q <= wr_data;
        RA_HI: begin
          hi_q    <= wr_data;
          cause_q <= wr_data;
        end
        default: ;
      endcase
    end
  end

  // R1: register writes outside the enabled banks leave state untouched
  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bank_ok) |=> ($stable(sel_q) && $stable(hi_q) && $stable(cause_q)));

  // R2: an upper-word write lands in both the upper-word and cause registers
  p_hi_to_cause_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && ra == RA_HI) |=> (hi_q == $past(wr_data) && cause_q == $past(wr_data)));

  // R9: the cause address is not writable
  p_cause_ro_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ra == RA_CAUSE) |=> $stable(cause_q));

  // R7: registers come out of reset cleared
  p_reset_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == '0 && hi_q == '0 && cause_q == '0));
endmodule

// File: rtl/tlbw_bank.sv
module tlbw_bank #(
  parameter int ENT_W = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [ENT_W-1:0] rdata,
  output logic             rvld
);
  localparam int DEPTH = 1 << AW;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // storage array: no reset, read-first, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // per-entry valid flags give the cleared-after-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rvld  <= 1'b0;
    end else begin
      if (we) vld_q[waddr] <= 1'b1;
      rvld <= vld_q[raddr];
    end
  end

  // R4: a commit marks its entry as holding data
  p_commit_marks_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> vld_q[$past(waddr)]);
endmodule

// File: rtl/tlbw_port.sv
module tlbw_port #(
  parameter int DATA_W  = 32,
  parameter int BANK_W  = 4,
  parameter int IDX_W   = 4,
  parameter int SET_W   = 2,
  parameter int NUM_ARR = 2,
  localparam int ARR_W  = (NUM_ARR > 1) ? $clog2(NUM_ARR) : 1,
  localparam int AW     = SET_W + IDX_W,
  localparam int ENT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BANK_W-1:0] reg_bank,
  output logic [DATA_W-1:0] sel_q,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] cause_q,
  input  logic [ARR_W-1:0]  lk_arr,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_hi,
  output logic [DATA_W-1:0] lk_lo
);
  logic               commit;
  logic [NUM_ARR-1:0] we_vec;
  logic [ENT_W-1:0]   rd_ent [NUM_ARR];
  logic [NUM_ARR-1:0] rd_vld;
  logic [ARR_W-1:0]   lk_arr_q;
  logic [AW-1:0]      waddr;
  logic [ENT_W-1:0]   sel_ent;
  logic               sel_vld;

  tlbw_regs #(.DATA_W(DATA_W), .BANK_W(BANK_W), .NUM_ARR(NUM_ARR)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reg_bank(reg_bank), .sel_q(sel_q), .hi_q(hi_q), .cause_q(cause_q),
    .commit(commit)
  );

  // entry address: set above index, both taken from the selector
  assign waddr = sel_q[AW-1:0];

  for (genvar g = 0; g < NUM_ARR; g++) begin : g_arr
    assign we_vec[g] = commit && (reg_bank == BANK_W'(g + 1));
    tlbw_bank #(.ENT_W(ENT_W), .AW(AW)) i_bank (
      .clk(clk), .rst(rst), .we(we_vec[g]), .waddr(waddr),
      .wdata({cause_q, wr_data}), .raddr({lk_set, lk_idx}),
      .rdata(rd_ent[g]), .rvld(rd_vld[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lk_arr_q <= '0;
    else     lk_arr_q <= lk_arr;
  end

  always_comb begin
    sel_ent = '0;
    sel_vld = 1'b0;
    for (int k = 0; k < NUM_ARR; k++) begin
      if (lk_arr_q == ARR_W'(k)) begin
        sel_ent = rd_ent[k];
        sel_vld = rd_vld[k];
      end
    end
  end

  assign lk_hi = sel_vld ? sel_ent[ENT_W-1:DATA_W] : '0;
  assign lk_lo = sel_vld ? sel_ent[DATA_W-1:0]     : '0;

  // R5: at most one array receives any commit
  p_one_array_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_vec));

  // R1: a commit never reaches an array outside the enabled banks
  p_no_stray_commit_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_bank == '0 || reg_bank > BANK_W'(NUM_ARR)) |-> (we_vec == '0));
endmodule

// File: tb/test_tlbw_port.sv
`timescale 1ns/1ps
module test_tlbw_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  reg_bank;
  logic [31:0] sel_q, hi_q, cause_q, lk_hi, lk_lo;
  logic        lk_arr;
  logic [1:0]  lk_set;
  logic [3:0]  lk_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tlbw_port i_tlbw_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reg_bank(reg_bank), .sel_q(sel_q), .hi_q(hi_q), .cause_q(cause_q),
    .lk_arr(lk_arr), .lk_set(lk_set), .lk_idx(lk_idx), .lk_hi(lk_hi), .lk_lo(lk_lo)
  );

  typedef struct packed {
    logic [3:0]  bank;
    logic [1:0]  set;
    logic [3:0]  idx;
    logic [31:0] hi;
    logic [31:0] lo;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 2'd0, 4'd0,  32'h1111_0001, 32'hAAAA_0001},
    '{4'd1, 2'd3, 4'd15, 32'h1111_0002, 32'hAAAA_0002},
    '{4'd2, 2'd0, 4'd0,  32'h2222_0003, 32'hBBBB_0003},
    '{4'd2, 2'd2, 4'd7,  32'h2222_0004, 32'hBBBB_0004},
    '{4'd7, 2'd1, 4'd1,  32'h7777_0005, 32'hCCCC_0005},
    '{4'd0, 2'd1, 4'd2,  32'h0000_0006, 32'hDDDD_0006},
    '{4'd1, 2'd1, 4'd5,  32'h1111_0007, 32'hAAAA_0007}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] b, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; reg_bank = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic a, input logic [1:0] s, input logic [3:0] i);
    @(negedge clk);
    lk_arr = a; lk_set = s; lk_idx = i;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; reg_bank = 4'd1;
    lk_arr = 1'b0; lk_set = '0; lk_idx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7: reset state of registers and entries
    chk("R7 sel", sel_q, 0);
    chk("R7 hi", hi_q, 0);
    chk("R7 cause", cause_q, 0);
    look(1'b1, 2'd3, 4'd15);
    chk("R7 entry lo", lk_lo, 0);
    chk("R7 entry hi", lk_hi, 0);

    // table walk: program every row (R1, R3, R4, R5)
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v].bank, 2'd0, {26'd0, VEC[v].set, VEC[v].idx});
      wr(VEC[v].bank, 2'd1, VEC[v].hi);
      wr(VEC[v].bank, 2'd2, VEC[v].lo);
    end
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].bank == 4'd1 || VEC[v].bank == 4'd2) begin
        look(VEC[v].bank == 4'd2, VEC[v].set, VEC[v].idx);
        chk("R4 R5 entry lo", lk_lo, VEC[v].lo);
        chk("R4 R5 entry hi", lk_hi, VEC[v].hi);
      end else begin
        for (int a = 0; a < 2; a++) begin
          look(a[0], VEC[v].set, VEC[v].idx);
          chk("R1 ignored entry lo", lk_lo, 0);
          chk("R1 ignored entry hi", lk_hi, 0);
        end
      end
    end
    // R5: entries written in array 1 do not appear in array 0
    look(1'b0, 2'd2, 4'd7);
    chk("R5 other array", lk_lo, 0);

    // R3 and R2: register readback
    wr(4'd2, 2'd0, 32'h0000_0029);
    chk("R3 sel", sel_q, 32'h0000_0029);
    wr(4'd1, 2'd1, 32'hFEED_0001);
    chk("R2 hi", hi_q, 32'hFEED_0001);
    chk("R2 cause", cause_q, 32'hFEED_0001);

    // R1: register writes in a disabled bank
    wr(4'd3, 2'd0, 32'h0000_0011);
    chk("R1 sel kept", sel_q, 32'h0000_0029);
    wr(4'd0, 2'd1, 32'h0BAD_0BAD);
    chk("R1 hi kept", hi_q, 32'hFEED_0001);
    chk("R1 cause kept", cause_q, 32'hFEED_0001);

    // R9: cause address is read-only
    wr(4'd1, 2'd3, 32'h0DEA_DBEE);
    chk("R9 cause kept", cause_q, 32'hFEED_0001);

    // R6: lookup parked on the entry being committed (set 2, index 9, array 1)
    look(1'b1, 2'd2, 4'd9);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h5A5A_0009; reg_bank = 4'd2;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6 same-edge old", lk_lo, 0);
    @(negedge clk);
    chk("R6 next-edge lo", lk_lo, 32'h5A5A_0009);
    chk("R6 next-edge hi", lk_hi, 32'hFEED_0001);

    // R8: later upper-word write leaves the stored entry alone
    wr(4'd2, 2'd1, 32'h9999_9999);
    look(1'b1, 2'd2, 4'd9);
    chk("R8 entry hi kept", lk_hi, 32'hFEED_0001);

    // R7: reset clears committed entries and registers again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look(1'b1, 2'd2, 4'd9);
    chk("R7 entry after reset", lk_lo, 0);
    chk("R7 cause after reset", cause_q, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule